// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialization

This block is an on-chip scratchpad memory split into a power-of-two number of 32-bit banks. It takes one vector request per cycle from a group of lanes. Each lane brings an active bit, a word address, a store enable and store data. The low address bits select the bank and the remaining bits select the row inside that bank. When active lanes need different words held in the same bank, the block cannot serve them together. It splits the request into the smallest number of passes in which no bank is asked for two different words.

In each pass, every bank serves one word: the word wanted by the lowest-numbered lane that is still pending on that bank. Every pending lane that wants that same word is served in the same pass, so a broadcast read costs nothing extra. While a request is being split into passes, the input ready signal stays low. After the final pass the block raises a one-cycle done pulse. It also presents the number of passes used, and holds every lane's read data until the next request is accepted.

A legacy setting with half as many banks is chosen by a parameter. Padding a row stride by one word, for example using a stride of 33 instead of 32, spreads the lanes over distinct banks, so the request completes in a single pass.

Top module: `sp_banked_scratchpad`

## Requirements
- R1: The bank of a lane is the low BANK_BITS bits of its word address and the row is the remaining upper bits. Consecutive 32-bit words sit in consecutive banks, and word 2^BANK_BITS wraps back to bank 0.
- R2: pass_count equals the largest number of distinct words requested from any single bank by the active lanes. Stride 1 needs 1 pass, stride 2 needs 2 passes and stride 32 needs 32 passes in the 32-bank setting.
- R3: Active lanes that address the identical word count as one word, are served in the same pass, and all receive that word's data.
- R4: The done pulse appears exactly pass_count clock cycles after the edge that accepted the request.
- R5: req_ready is low in every cycle after acceptance until the final pass has finished, and it is high in the cycle done is high.
- R6: When several active lanes store to the same word in one request, the data of the highest-numbered of those lanes is the word's new value.
- R7: Inactive lanes have no effect. They never store anything, they never add passes, and their rsp_rdata slice reads zero.
- R8: Every served lane, store or load, returns the word's contents from before the stores of its own pass. A load and a store to the same word in one request take a single pass.
- R9: A request with no active lanes completes with done high in the next cycle and pass_count equal to 0.
- R10: rsp_rdata and pass_count stay unchanged from done until the next request is accepted.
- R11: With BANK_BITS = 4 there are 16 banks. Stride 1 over 32 lanes then needs 2 passes, and stride 33 needs 2 passes.
- R12: A stride of 33 words over all 32 lanes completes in 1 pass in the 32-bank setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A vector request is offered |
| req_ready | output | 1 | The block can accept a request this cycle |
| req_active | input | LANES | Per-lane active bit |
| req_addr | input | LANES*ADDR_W | Per-lane word address, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_we | input | LANES | Per-lane store enable |
| req_wdata | input | LANES*DATA_W | Per-lane store data, lane i at bits [i*DATA_W +: DATA_W] |
| done | output | 1 | One-cycle pulse after the last lane is retired |
| rsp_rdata | output | LANES*DATA_W | Per-lane read data, held until the next acceptance |
| pass_count | output | $clog2(LANES+1) | Number of passes the last request used |

## Verification
The bench builds two copies side by side: one with BANK_BITS = 5 (32 banks) and one with BANK_BITS = 4 (16 banks). Both use 32 lanes and a 10-bit word address, and both receive identical stimulus. The same stride pattern therefore yields two different expected pass counts, which checks the bank mapping and the legacy setting together. Because the address is only 10 bits wide, a stride of 64 makes lane i and lane i+16 hit the very same word. This exercises broadcast merging and conflicts within a single request.

// File: rtl/sp_pkg.sv
package sp_pkg;

  // bank index: low bits of the word address
  function automatic logic [31:0] sp_bank_of(input logic [31:0] waddr, input int unsigned bbits);
    return waddr & ((32'd1 << bbits) - 32'd1);
  endfunction

  // row inside a bank: the address bits above the bank field
  function automatic logic [31:0] sp_row_of(input logic [31:0] waddr, input int unsigned bbits);
    return waddr >> bbits;
  endfunction

endpackage

// File: rtl/sp_pass_arbiter.sv
module sp_pass_arbiter #(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 10,
  parameter int BANK_BITS = 5
) (
  input  logic [LANES-1:0]  pending,
  input  logic [ADDR_W-1:0] addr [LANES],
  output logic [LANES-1:0]  lead,
  output logic [LANES-1:0]  served
);

  logic [31:0] lane_bank [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_bank
    assign lane_bank[i] = sp_pkg::sp_bank_of(32'(addr[i]), BANK_BITS);
  end

  // a leader is the lowest-numbered pending lane of its bank
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lead[i] = pending[i];
      for (int j = 0; j < i; j++) begin
        if (pending[j] && lane_bank[j] == lane_bank[i]) lead[i] = 1'b0;
      end
    end
  end

  // every pending lane sharing a leader's word rides along in this pass
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      served[i] = 1'b0;
      for (int j = 0; j < LANES; j++) begin
        if (pending[i] && lead[j] && addr[j] == addr[i]) served[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sp_bank_route.sv
module sp_bank_route #(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 10,
  parameter int BANK_BITS = 5,
  parameter int DATA_W    = 32,
  localparam int BANKS    = 1 << BANK_BITS,
  localparam int ROW_W    = ADDR_W - BANK_BITS
) (
  input  logic [LANES-1:0]  lead,
  input  logic [LANES-1:0]  served,
  input  logic [LANES-1:0]  we,
  input  logic [ADDR_W-1:0] addr  [LANES],
  input  logic [DATA_W-1:0] wdata [LANES],
  output logic [ROW_W-1:0]  rd_row  [BANKS],
  output logic [BANKS-1:0]  wr_en,
  output logic [ROW_W-1:0]  wr_row  [BANKS],
  output logic [DATA_W-1:0] wr_data [BANKS]
);

  logic [BANK_BITS-1:0] lbank [LANES];
  logic [ROW_W-1:0]     lrow  [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign lbank[i] = BANK_BITS'(sp_pkg::sp_bank_of(32'(addr[i]), BANK_BITS));
    assign lrow[i]  = ROW_W'(sp_pkg::sp_row_of(32'(addr[i]), BANK_BITS));
  end

  // ascending scan: the last matching store lane (highest number) wins
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      rd_row[b]  = '0;
      wr_en[b]   = 1'b0;
      wr_row[b]  = '0;
      wr_data[b] = '0;
      for (int i = 0; i < LANES; i++) begin
        if (lbank[i] == BANK_BITS'(b)) begin
          if (lead[i]) rd_row[b] = lrow[i];
          if (served[i] && we[i]) begin
            wr_en[b]   = 1'b1;
            wr_row[b]  = lrow[i];
            wr_data[b] = wdata[i];
          end
        end
      end
    end
  end

endmodule

// File: rtl/sp_bank_store.sv
module sp_bank_store #(
  parameter int BANKS  = 32,
  parameter int ROW_W  = 5,
  parameter int DATA_W = 32,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic              clk,
  input  logic [ROW_W-1:0]  rd_row  [BANKS],
  output logic [DATA_W-1:0] rd_data [BANKS],
  input  logic [BANKS-1:0]  wr_en,
  input  logic [ROW_W-1:0]  wr_row  [BANKS],
  input  logic [DATA_W-1:0] wr_data [BANKS]
);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
      if (wr_en[b]) mem[wr_row[b]] <= wr_data[b];
    end

    // read sees contents before this edge's store
    assign rd_data[b] = mem[rd_row[b]];
  end

endmodule

// File: rtl/sp_banked_scratchpad.sv
module sp_banked_scratchpad #(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 10,
  parameter int BANK_BITS = 5,
  parameter int DATA_W    = 32,
  localparam int BANKS    = 1 << BANK_BITS,
  localparam int ROW_W    = ADDR_W - BANK_BITS,
  localparam int PC_W     = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_active,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_we,
  input  logic [LANES*DATA_W-1:0] req_wdata,
  output logic                    done,
  output logic [LANES*DATA_W-1:0] rsp_rdata,
  output logic [PC_W-1:0]         pass_count
);

  // captured request and progress state
  logic                    busy;
  logic [LANES-1:0]        pend;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES*DATA_W-1:0] wdata_q;
  logic [LANES-1:0]        we_q;
  logic [LANES*DATA_W-1:0] rdata_q;
  logic                    done_q;
  logic [PC_W-1:0]         pcount_q;
  logic [PC_W-1:0]         pass_ctr;

  // named events for the checker
  logic accept;
  logic last_pass;

  logic [ADDR_W-1:0] lane_addr  [LANES];
  logic [DATA_W-1:0] lane_wdata [LANES];
  logic [DATA_W-1:0] lane_rd    [LANES];
  logic [LANES-1:0]  lead;
  logic [LANES-1:0]  served;

  logic [ROW_W-1:0]  rd_row  [BANKS];
  logic [DATA_W-1:0] bank_rd [BANKS];
  logic [BANKS-1:0]  wr_en;
  logic [ROW_W-1:0]  wr_row  [BANKS];
  logic [DATA_W-1:0] wr_data [BANKS];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BANK_BITS-1:0] lb;
    assign lane_addr[i]  = addr_q[i*ADDR_W +: ADDR_W];
    assign lane_wdata[i] = wdata_q[i*DATA_W +: DATA_W];
    assign lb            = BANK_BITS'(sp_pkg::sp_bank_of(32'(lane_addr[i]), BANK_BITS));
    assign lane_rd[i]    = bank_rd[lb];
  end

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign last_pass = busy && ((pend & ~served) == '0);

  sp_pass_arbiter #(
    .LANES(LANES), .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS)
  ) u_arb (
    .pending (pend),
    .addr    (lane_addr),
    .lead    (lead),
    .served  (served)
  );

  sp_bank_route #(
    .LANES(LANES), .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .DATA_W(DATA_W)
  ) u_route (
    .lead    (lead),
    .served  (served),
    .we      (we_q),
    .addr    (lane_addr),
    .wdata   (lane_wdata),
    .rd_row  (rd_row),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_data (wr_data)
  );

  sp_bank_store #(
    .BANKS(BANKS), .ROW_W(ROW_W), .DATA_W(DATA_W)
  ) u_store (
    .clk     (clk),
    .rd_row  (rd_row),
    .rd_data (bank_rd),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_data (wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pend     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
      pcount_q <= '0;
      pass_ctr <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        addr_q   <= req_addr;
        wdata_q  <= req_wdata;
        we_q     <= req_we & req_active;
        pend     <= req_active;
        busy     <= |req_active;
        rdata_q  <= '0;
        pass_ctr <= '0;
        if (req_active == '0) begin
          done_q   <= 1'b1;
          pcount_q <= '0;
        end
      end else if (busy) begin
        for (int i = 0; i < LANES; i++) begin
          if (served[i]) rdata_q[i*DATA_W +: DATA_W] <= lane_rd[i];
        end
        pend     <= pend & ~served;
        pass_ctr <= pass_ctr + 1'b1;
        if (last_pass) begin
          busy     <= 1'b0;
          done_q   <= 1'b1;
          pcount_q <= pass_ctr + 1'b1;
        end
      end
    end
  end

  assign done       = done_q;
  assign rsp_rdata  = rdata_q;
  assign pass_count = pcount_q;

endmodule

// File: rtl/sp_scratchpad_chk.sv
module sp_scratchpad_chk #(
  parameter int LANES     = 32,
  parameter int ADDR_W    = 10,
  parameter int BANK_BITS = 5,
  parameter int DATA_W    = 32,
  localparam int PC_W     = $clog2(LANES + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_ready,
  input logic [LANES-1:0]        req_active,
  input logic                    done,
  input logic [PC_W-1:0]         pass_count,
  input logic [LANES*DATA_W-1:0] rsp_rdata,
  input logic                    busy,
  input logic                    accept,
  input logic [LANES-1:0]        served,
  input logic [LANES*ADDR_W-1:0] addr_q
);

  // true when no two served lanes want different words of one bank
  function automatic logic clash_free(input logic [LANES-1:0] s, input logic [LANES*ADDR_W-1:0] a);
    logic ok;
    logic [31:0] ai, aj;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      for (int j = 0; j < LANES; j++) begin
        ai = 32'(a[i*ADDR_W +: ADDR_W]);
        aj = 32'(a[j*ADDR_W +: ADDR_W]);
        if (s[i] && s[j] && ai != aj &&
            sp_pkg::sp_bank_of(ai, BANK_BITS) == sp_pkg::sp_bank_of(aj, BANK_BITS))
          ok = 1'b0;
      end
    end
    return ok;
  endfunction

  // R2
  bank_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> clash_free(served, addr_q));

  // R2
  pass_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (served != '0));

  // R2
  pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass_count <= PC_W'(LANES)));

  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_active != '0) |=> !req_ready);

  // R5
  ready_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R9
  empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_active == '0) |=> (done && pass_count == '0));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !busy) |=> ($stable(rsp_rdata) && $stable(pass_count)));

endmodule

bind sp_banked_scratchpad sp_scratchpad_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .req_active (req_active),
  .done       (done),
  .pass_count (pass_count),
  .rsp_rdata  (rsp_rdata),
  .busy       (busy),
  .accept     (accept),
  .served     (served),
  .addr_q     (addr_q)
);

// File: tb/sp_banked_scratchpad_bench.sv
`timescale 1ns/1ps
module sp_banked_scratchpad_bench;

  localparam int LANES  = 32;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int PC_W   = $clog2(LANES + 1);
  localparam int NVEC   = 12;

  // entry: {active mask, base, stride, passes@32 banks, passes@16 banks}
  localparam logic [63:0] TABLE [NVEC] = '{
    {32'hFFFF_FFFF, 10'd0,   10'd1,  6'd1,  6'd2},   // R1 R2 R11 stride 1
    {32'hFFFF_FFFF, 10'd0,   10'd2,  6'd2,  6'd4},   // R2 stride 2
    {32'hFFFF_FFFF, 10'd0,   10'd32, 6'd32, 6'd32},  // R2 stride 32
    {32'hFFFF_FFFF, 10'd3,   10'd33, 6'd1,  6'd2},   // R12 R11 padded stride
    {32'hFFFF_FFFF, 10'd100, 10'd0,  6'd1,  6'd1},   // R3 broadcast
    {32'hFFFF_FFFF, 10'd0,   10'd16, 6'd16, 6'd32},  // R2 R11 stride 16
    {32'h0000_FFFF, 10'd0,   10'd1,  6'd1,  6'd1},   // R7 half active
    {32'h0000_FFFF, 10'd0,   10'd2,  6'd1,  6'd2},   // R7 R11
    {32'h0000_0005, 10'd0,   10'd32, 6'd2,  6'd2},   // R7 two lanes
    {32'h0000_0000, 10'd0,   10'd1,  6'd0,  6'd0},   // R9 empty
    {32'hAAAA_AAAA, 10'd7,   10'd1,  6'd1,  6'd2},   // R7 odd lanes
    {32'hFFFF_FFFF, 10'd0,   10'd64, 6'd16, 6'd16}   // R3 aliasing + conflict
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [LANES-1:0] req_active = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic [LANES-1:0] req_we = '0;
  logic [LANES*DATA_W-1:0] req_wdata = '0;

  logic ready_a, done_a, ready_b, done_b;
  logic [LANES*DATA_W-1:0] rdata_a, rdata_b;
  logic [PC_W-1:0] pc_a, pc_b;

  int checks = 0;
  int failures = 0;
  int lat_a, lat_b;
  logic rdy_a0, rdy_b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sp_banked_scratchpad #(.LANES(LANES), .ADDR_W(ADDR_W), .BANK_BITS(5), .DATA_W(DATA_W)) u_sp_banked_scratchpad (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready_a),
    .req_active(req_active), .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .done(done_a), .rsp_rdata(rdata_a), .pass_count(pc_a));

  sp_banked_scratchpad #(.LANES(LANES), .ADDR_W(ADDR_W), .BANK_BITS(4), .DATA_W(DATA_W)) u_sp_banked_scratchpad_b16 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready_b),
    .req_active(req_active), .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .done(done_b), .rsp_rdata(rdata_b), .pass_count(pc_b));

  function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
    return {6'h2A, a, ~a, 6'h15};
  endfunction

  function automatic logic [ADDR_W-1:0] lane_word(input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] stride, input int lane);
    return ADDR_W'(32'(base) + 32'(lane) * 32'(stride));
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_stride(input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] stride);
    for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = lane_word(base, stride, l);
  endtask

  task automatic run_req(input logic [LANES-1:0] act, input logic [LANES-1:0] wen);
    @(negedge clk);
    req_valid = 1'b1;
    req_active = act;
    req_we = wen;
    @(negedge clk);
    req_valid = 1'b0;
    rdy_a0 = ready_a;
    rdy_b0 = ready_b;
    lat_a = -1;
    lat_b = -1;
    for (int k = 0; k < 100; k++) begin
      if (k > 0) @(negedge clk);
      if (done_a && lat_a < 0) lat_a = k;
      if (done_b && lat_b < 0) lat_b = k;
      if (lat_a >= 0 && lat_b >= 0) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [LANES*DATA_W-1:0] held_a;
    logic [PC_W-1:0] held_pc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R5 R10)
    check(ready_a && ready_b, "R5 reset ready", {ready_a, ready_b}, 2'b11);
    check(!done_a && !done_b, "R10 reset done", {done_a, done_b}, 0);
    check(pc_a == 0 && pc_b == 0, "R10 reset pass_count", {pc_a, pc_b}, 0);
    check(rdata_a == '0 && rdata_b == '0, "R7 reset rdata", rdata_a[63:0], 0);

    // preload every word with pat(addr)
    for (int blk = 0; blk < (1 << ADDR_W) / LANES; blk++) begin
      set_stride(ADDR_W'(blk * LANES), 10'd1);
      for (int l = 0; l < LANES; l++)
        req_wdata[l*DATA_W +: DATA_W] = pat(lane_word(ADDR_W'(blk * LANES), 10'd1, l));
      run_req('1, '1);
    end
    req_wdata = '0;

    // vector table (R1 R2 R3 R4 R5 R7 R9 R11 R12)
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] m;
      logic [ADDR_W-1:0] base, stride;
      logic [5:0] e32, e16;
      int bad_a, bad_b;
      logic [DATA_W-1:0] got_a, got_b, want;
      {m, base, stride, e32, e16} = TABLE[v];
      set_stride(base, stride);
      run_req(m, '0);
      check(pc_a == PC_W'(e32), $sformatf("R2 vec%0d pass_count 32 banks", v), pc_a, e32);
      check(pc_b == PC_W'(e16), $sformatf("R11 vec%0d pass_count 16 banks", v), pc_b, e16);
      check(lat_a == int'(e32), $sformatf("R4 vec%0d latency 32 banks", v), lat_a, e32);
      check(lat_b == int'(e16), $sformatf("R4 vec%0d latency 16 banks", v), lat_b, e16);
      if (e32 > 0) check(!rdy_a0 && !rdy_b0, $sformatf("R5 vec%0d ready low while serial", v), {rdy_a0, rdy_b0}, 0);
      bad_a = -1; bad_b = -1; got_a = '0; got_b = '0; want = '0;
      for (int l = 0; l < LANES; l++) begin
        logic [DATA_W-1:0] w;
        w = m[l] ? pat(lane_word(base, stride, l)) : '0;
        if (bad_a < 0 && rdata_a[l*DATA_W +: DATA_W] != w) begin bad_a = l; got_a = rdata_a[l*DATA_W +: DATA_W]; want = w; end
        if (bad_b < 0 && rdata_b[l*DATA_W +: DATA_W] != w) begin bad_b = l; got_b = rdata_b[l*DATA_W +: DATA_W]; want = w; end
      end
      check(bad_a < 0, $sformatf("R3 R7 vec%0d read data 32 banks lane %0d", v, bad_a), got_a, want);
      check(bad_b < 0, $sformatf("R3 R7 vec%0d read data 16 banks lane %0d", v, bad_b), got_b, want);
    end

    // R10: results stay put while idle
    held_a = rdata_a;
    held_pc = pc_a;
    repeat (3) @(negedge clk);
    check(rdata_a == held_a && pc_a == held_pc, "R10 result hold", rdata_a[63:0], held_a[63:0]);

    // R6: all lanes store to word 5, highest lane wins
    set_stride(10'd5, 10'd0);
    for (int l = 0; l < LANES; l++) req_wdata[l*DATA_W +: DATA_W] = 32'h1000 + 32'(l);
    run_req('1, '1);
    check(pc_a == 1, "R3 R6 same-word stores one pass", pc_a, 1);
    set_stride(10'd5, 10'd0);
    run_req(32'h1, '0);
    check(rdata_a[DATA_W-1:0] == 32'h101F, "R6 highest lane store wins", rdata_a[DATA_W-1:0], 32'h101F);

    // R6 R7: inactive lanes with store enable leave no mark
    set_stride(10'd6, 10'd0);
    for (int l = 0; l < LANES; l++) req_wdata[l*DATA_W +: DATA_W] = 32'h2000 + 32'(l);
    run_req(32'h0000_03FF, '1);
    run_req(32'h1, '0);
    check(rdata_a[DATA_W-1:0] == 32'h2009, "R7 inactive store ignored", rdata_a[DATA_W-1:0], 32'h2009);
    check(rdata_b[DATA_W-1:0] == 32'h2009, "R7 inactive store ignored 16 banks", rdata_b[DATA_W-1:0], 32'h2009);

    // R8: load and store to word 7 in one request
    set_stride(10'd7, 10'd0);
    req_wdata = '0;
    req_wdata[1*DATA_W +: DATA_W] = 32'hDEAD_BEEF;
    run_req(32'h3, 32'h2);
    check(rdata_a[DATA_W-1:0] == pat(10'd7), "R8 load sees old word", rdata_a[DATA_W-1:0], pat(10'd7));
    check(pc_a == 1, "R8 load+store same word one pass", pc_a, 1);
    run_req(32'h1, '0);
    check(rdata_a[DATA_W-1:0] == 32'hDEAD_BEEF, "R8 store landed", rdata_a[DATA_W-1:0], 32'hDEAD_BEEF);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule